// File: doc/BRIEF.md
# Legacy Interrupt Line to Message Write Bridge

This block sits at a host bridge and converts level-sensitive legacy interrupt lines (four by default, lines A to D) into memory writes. The rest of the system then only has to handle message-signalled interrupts. Each line is synchronized, and its level is compared with the level last reported for it. A rising level produces one write built from the line's "set" vector, aimed at an interrupt-set register. A falling level produces one write built from the line's "clear" vector, aimed at an interrupt-clear register. The interrupt controller therefore sees the line's level as a sequence of set and clear writes.

Writes leave on a valid/ready channel that carries a 64-bit address and a 32-bit data word. The output holds one message at a time. A write-only configuration port programs the vectors and a per-line enable mask. The block does not interpret any address or data value.

Top module: `intx_msg_bridge`

## Requirements
- R1: After reset `msg_valid` is low, every line is treated as deasserted, and every vector address and data word is zero. A line that is already high when it is first enabled produces a write with address 0 and data 0.
- R2: When an enabled line goes from low to high, exactly one write is emitted, carrying that line's set-vector address and data.
- R3: When an enabled line goes from high to low, exactly one write is emitted, carrying that line's clear-vector address and data.
- R4: Configuration map. When `cfg_addr[5]` is 0, the address selects a vector: bits [4:3] are the line (0=A to 3=D), bit [2] is the kind (0=set, 1=clear) and bits [1:0] are the word. Word 0 is address bits 31:0, word 1 is address bits 63:32, word 2 is data, and word 3 is ignored. When `cfg_addr[5]` is 1, `cfg_wdata[3:0]` becomes the enable mask, with bit n for line n.
- R5: Lines with pending messages are served in fixed priority order: A first, then B, C and D.
- R6: If a line changes level and changes back before its message has been taken into the output register, nothing is sent for it. Only the newest level is ever reported.
- R7: A disabled line sends nothing and its reported level is frozen. The enable mask resets to all zero. Enabling a line whose level differs from its reported level sends one write for the current level.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady. Each edge produces at most one accepted write.
- R9: A write is consumed only on a cycle where both `msg_valid` and `msg_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_in | input | 4 | Legacy interrupt levels, bit 0 = line A |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| msg_valid | output | 1 | Message write available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Single isolated rising and falling edges with distinct vectors show that the set and clear vectors are kept apart and that every word of the map reaches the intended field. Four lines rising together against a stalled consumer expose the service order. A short pulse hidden behind a stalled message separates newest-level reporting from edge queuing. Toggling the enable mask while a line is held shows that a disabled line is frozen rather than lost. Random single-line toggles, random vector reprogramming and random stall lengths then compare every accepted write with a bench-side mirror of the vectors.

// File: rtl/intx_msg_pkg.sv
`timescale 1ns/1ps
package intx_msg_pkg;
   // Vector kind, also the kind bit of the configuration address
   typedef enum logic {
      VEC_SET = 1'b0,
      VEC_CLR = 1'b1
   } vec_kind_e;

   // Word selector within a vector
   typedef enum logic [1:0] {
      WORD_ADDR_LO = 2'd0,
      WORD_ADDR_HI = 2'd1,
      WORD_DATA    = 2'd2,
      WORD_NONE    = 2'd3
   } vec_word_e;

   function automatic int unsigned line_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/intx_sync.sv
`timescale 1ns/1ps
module intx_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("intx_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("intx_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/intx_vec_regs.sv
`timescale 1ns/1ps
module intx_vec_regs
   import intx_msg_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int ADDR_W    = 64,
   parameter int DATA_W    = 32,
   parameter int CFG_DW    = 32,
   localparam int LINE_W   = line_bits(NUM_LINES),
   localparam int SLOT_W   = LINE_W + 1,
   localparam int SLOTS    = 2 * NUM_LINES,
   localparam int CFG_AW   = LINE_W + 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [CFG_AW-1:0]                 cfg_addr,
   input  logic [CFG_DW-1:0]                 cfg_wdata,
   output logic [NUM_LINES-1:0]              line_en,
   output logic [SLOTS-1:0][ADDR_W-1:0]      vec_addr,
   output logic [SLOTS-1:0][DATA_W-1:0]      vec_data
);
   if (ADDR_W != 2 * CFG_DW) begin : g_bad_addr
      $error("intx_vec_regs: ADDR_W must equal two configuration words");
   end
   if (DATA_W > CFG_DW) begin : g_bad_data
      $error("intx_vec_regs: DATA_W must fit one configuration word");
   end
   if (NUM_LINES > CFG_DW) begin : g_bad_lines
      $error("intx_vec_regs: enable mask must fit one configuration word");
   end

   logic              sel_mask;
   logic [SLOT_W-1:0] slot_idx;
   vec_word_e         word_sel;

   assign sel_mask = cfg_addr[CFG_AW-1];
   assign slot_idx = cfg_addr[SLOT_W+1:2];
   assign word_sel = vec_word_e'(cfg_addr[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  line_en <= '0;
      else if (cfg_we && sel_mask) line_en <= cfg_wdata[NUM_LINES-1:0];
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = cfg_we && !sel_mask && (slot_idx == SLOT_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vec_addr[s] <= '0;
            vec_data[s] <= '0;
         end else if (hit) begin
            case (word_sel)
               WORD_ADDR_LO: vec_addr[s][CFG_DW-1:0]      <= cfg_wdata;
               WORD_ADDR_HI: vec_addr[s][ADDR_W-1:CFG_DW] <= cfg_wdata;
               WORD_DATA:    vec_data[s]                  <= cfg_wdata[DATA_W-1:0];
               default: ;
            endcase
         end
      end

      // R4: vector storage only moves on a configuration write
      assert_vec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_we |=> ($stable(vec_addr[s]) && $stable(vec_data[s])));
   end
endmodule

// File: rtl/intx_edge_arb.sv
`timescale 1ns/1ps
module intx_edge_arb #(
   parameter int NUM_LINES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lvl,
   input  logic [NUM_LINES-1:0] line_en,
   input  logic                 take,
   output logic [NUM_LINES-1:0] grant,
   output logic                 grant_lvl
);
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("intx_edge_arb: NUM_LINES must be at least 1");
   end

   logic [NUM_LINES-1:0] reported;
   logic [NUM_LINES-1:0] pending;
   logic [NUM_LINES-1:0] lowest;

   // A line is pending while its current level differs from what was sent
   assign pending   = line_en & (lvl ^ reported);
   assign lowest    = pending & (~pending + NUM_LINES'(1));
   assign grant     = take ? lowest : '0;
   assign grant_lvl = |(grant & lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reported <= '0;
      else        reported <= (reported & ~grant) | (lvl & grant);
   end

   // R5: at most one line is served per cycle
   assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
      // R8: a served level is not served again unless the level moved
      assert_no_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |=> (!pending[i] || (lvl[i] != $past(lvl[i]))));
      // R7: a disabled line keeps its reported level
      assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !line_en[i] |=> (reported[i] == $past(reported[i])));
   end
endmodule

// File: rtl/intx_msg_bridge.sv
`timescale 1ns/1ps
module intx_msg_bridge
   import intx_msg_pkg::*;
#(
   parameter int NUM_LINES   = 4,
   parameter int ADDR_W      = 64,
   parameter int DATA_W      = 32,
   parameter int CFG_DW      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int LINE_W     = line_bits(NUM_LINES),
   localparam int CFG_AW     = LINE_W + 4,
   localparam int SLOTS      = 2 * NUM_LINES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] intx_in,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [CFG_DW-1:0]    cfg_wdata,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [ADDR_W-1:0]    msg_addr,
   output logic [DATA_W-1:0]    msg_data
);
   logic [NUM_LINES-1:0]         lvl;
   logic [NUM_LINES-1:0]         line_en;
   logic [SLOTS-1:0][ADDR_W-1:0] vec_addr;
   logic [SLOTS-1:0][DATA_W-1:0] vec_data;
   logic [NUM_LINES-1:0]         grant;
   logic                         grant_lvl;
   logic                         take;
   logic [ADDR_W-1:0]            pick_addr;
   logic [DATA_W-1:0]            pick_data;

   intx_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(intx_in), .dout(lvl)
   );

   intx_vec_regs #(
      .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_DW(CFG_DW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .line_en(line_en),
      .vec_addr(vec_addr), .vec_data(vec_data)
   );

   // The output register accepts a new message when empty or draining
   assign take = !msg_valid || msg_ready;

   intx_edge_arb #(.NUM_LINES(NUM_LINES)) u_arb (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .line_en(line_en),
      .take(take), .grant(grant), .grant_lvl(grant_lvl)
   );

   // Slot 2*l holds the set vector, slot 2*l+1 the clear vector
   always_comb begin
      pick_addr = '0;
      pick_data = '0;
      for (int l = 0; l < NUM_LINES; l++) begin
         if (grant[l]) begin
            pick_addr = grant_lvl ? vec_addr[2*l] : vec_addr[2*l+1];
            pick_data = grant_lvl ? vec_data[2*l] : vec_data[2*l+1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (|grant) begin
         msg_valid <= 1'b1;
         msg_addr  <= pick_addr;
         msg_data  <= pick_data;
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end

   // R8: a stalled message keeps its content
   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
   // R9: without a handshake an offered message is not withdrawn
   assert_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> msg_valid);
endmodule

// File: tb/intx_msg_bridge_bench.sv
`timescale 1ns/1ps
module intx_msg_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  intx_in = '0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        msg_valid;
   logic        msg_ready = 1'b1;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [63:0] ma [4][2];
   logic [31:0] md [4][2];
   logic [95:0] q [$];

   always #10 clk = ~clk;   // 50 MHz

   intx_msg_bridge u_intx_msg_bridge (
      .clk(clk), .rst_n(rst_n), .intx_in(intx_in), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   // Inputs change 2 ns after posedge, so valid&&ready at negedge means a handshake
   always @(negedge clk)
      if (rst_n && msg_valid && msg_ready) q.push_back({msg_addr, msg_data});

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
   endtask

   task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      step(1);
      cfg_we = 1'b0;
   endtask

   task automatic prog_vec(input int l, input int k, input logic [63:0] a, input logic [31:0] d);
      logic [5:0] base;
      base = {1'b0, 2'(l), 1'(k), 2'b00};
      cfg_write(base | 6'd0, a[31:0]);
      cfg_write(base | 6'd1, a[63:32]);
      cfg_write(base | 6'd2, d);
      cfg_write(base | 6'd3, 32'hDEAD_BEEF);   // ignored word
      ma[l][k] = a;
      md[l][k] = d;
   endtask

   function automatic logic [95:0] exp_msg(input int l, input bit level);
      int k;
      k = level ? 0 : 1;
      return {ma[l][k], md[l][k]};
   endfunction

   task automatic expect_msg(input string req, input logic [95:0] exp);
      int t;
      t = 0;
      while (q.size() == 0 && t < 60) begin @(negedge clk); t++; end
      if (q.size() == 0) check(req, 96'hX, exp);
      else check(req, q.pop_front(), exp);
   endtask

   task automatic expect_none(input string req, input int n);
      step(n);
      check(req, 96'(q.size()), 96'd0);
      q.delete();
   endtask

   initial begin
      for (int l = 0; l < 4; l++)
         for (int k = 0; k < 2; k++) begin ma[l][k] = '0; md[l][k] = '0; end
   end

   initial begin : watchdog
      #(20ns * 150000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [95:0] held;
      bit lv [4];
      void'($urandom(32'd2024));
      for (int l = 0; l < 4; l++) lv[l] = 1'b0;

      // R1: line A high through reset, nothing enabled
      intx_in = 4'b0001;
      step(3);
      rst_n = 1'b1;
      step(1);
      @(negedge clk);
      check("R1 valid low after reset", 96'(msg_valid), 96'd0);
      step(1);
      expect_none("R7 nothing while all disabled", 10);
      cfg_write(6'b100000, 32'hF);
      expect_msg("R1 zero set vector", 96'd0);
      intx_in = 4'b0000;
      expect_msg("R1 zero clear vector", 96'd0);
      expect_none("R1 no extra", 8);

      // R4: program all vectors through the map
      for (int l = 0; l < 4; l++)
         for (int k = 0; k < 2; k++)
            prog_vec(l, k, {24'hFEE000, 8'(l), 24'h000C00, 8'(k)} ^ 64'h1234_5678_0000_0000,
                     32'hA5000000 | (l << 8) | k);

      // R2/R3: single line edges
      intx_in[1] = 1'b1; lv[1] = 1'b1;
      expect_msg("R2 set vector line B", exp_msg(1, 1'b1));
      intx_in[1] = 1'b0; lv[1] = 1'b0;
      expect_msg("R3 clear vector line B", exp_msg(1, 1'b0));
      expect_none("R8 one write per edge", 8);

      // R5: all lines together against a stall
      msg_ready = 1'b0;
      intx_in = 4'b1111;
      step(10);
      check("R9 nothing consumed while stalled", 96'(q.size()), 96'd0);
      msg_ready = 1'b1;
      for (int l = 0; l < 4; l++) expect_msg("R5 set order", exp_msg(l, 1'b1));
      intx_in = 4'b0000;
      for (int l = 0; l < 4; l++) expect_msg("R5 clear order", exp_msg(l, 1'b0));
      expect_none("R5 no extra", 8);

      // R8: stall stability
      msg_ready = 1'b0;
      intx_in[0] = 1'b1;
      step(6);
      @(negedge clk);
      held = {msg_addr, msg_data};
      check("R8 held message valid", 96'(msg_valid), 96'd1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check("R8 content stable", {msg_addr, msg_data}, held);
      end
      // R6: pulse on B while A stalls
      step(1);
      intx_in[1] = 1'b1;
      step(3);
      intx_in[1] = 1'b0;
      step(6);
      msg_ready = 1'b1;
      expect_msg("R6 only A set", exp_msg(0, 1'b1));
      expect_none("R6 no stale B pair", 15);
      intx_in[0] = 1'b0;
      expect_msg("R3 clear A", exp_msg(0, 1'b0));

      // R7: enable gating
      cfg_write(6'b100000, 32'hB);
      intx_in[2] = 1'b1;
      expect_none("R7 disabled C silent", 12);
      cfg_write(6'b100000, 32'hF);
      expect_msg("R7 enable sends set", exp_msg(2, 1'b1));
      cfg_write(6'b100000, 32'hB);
      intx_in[2] = 1'b0;
      expect_none("R7 disabled C silent on fall", 12);
      cfg_write(6'b100000, 32'hF);
      expect_msg("R7 enable sends clear", exp_msg(2, 1'b0));
      expect_none("R7 no extra", 8);

      // Random single-line toggles with reprogramming and stalls
      for (int i = 0; i < 60; i++) begin
         int l;
         int st;
         l = $urandom_range(0, 3);
         if ($urandom_range(0, 2) == 0)
            prog_vec(l, $urandom_range(0, 1), {$urandom, $urandom}, $urandom);
         st = $urandom_range(0, 5);
         msg_ready = (st == 0);
         lv[l] = ~lv[l];
         intx_in[l] = lv[l];
         step(st + 4);
         msg_ready = 1'b1;
         expect_msg(lv[l] ? "R2 random set" : "R3 random clear", exp_msg(l, lv[l]));
      end
      expect_none("R8 random no extra", 10);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule